// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block is one request generator channel that sits in front of a DMA request router. It watches one of 32 trigger lines, picked by a field in its control word. When the chosen kind of edge shows up on that line, it raises a request line toward the DMA side. It keeps that request up until a programmed number of acknowledges has come back, then drops it and waits for the next trigger. A trigger that lands while a burst still has more than one request to go counts as an overrun. That trigger is thrown away and a sticky flag is raised. The flag can drive an interrupt and is cleared by writing one to a separate clear location.

Software sets the block up through a small synchronous write port with a combinational read-back. Address 0 holds the control word, address 1 is the read-only status and address 2 is the write-one-to-clear location. The burst length field can only be changed while the channel is disabled, so a running burst always ends on the length it started with. Trigger lines and the acknowledge are assumed to be synchronous to the block clock.

Top module: `burst_req_gen`

## Requirements
- R1: After reset, dmaReq, irqOut and ovrFlag are 0 and every register location reads 0.
- R2: Control word at address 0, read back with all unlisted bits as 0:
  - bits [4:0] select the trigger line;
  - bit 8 enables the interrupt;
  - bit 16 enables the channel;
  - bits [18:17] choose the edge, with 00 none, 01 rising, 10 falling, 11 both;
  - bits [23:19] hold the burst length code L.
- R3: With the channel enabled, a matching edge on the selected line raises dmaReq in the cycle after the edge is first seen on trigIn.
- R4: Each trigger produces exactly L+1 requests. dmaReq stays high and each cycle with dmaAck high counts one request. dmaReq falls in the cycle after the acknowledge of the last request.
- R5: Edges are ignored while the enable bit is 0, and edges on lines other than the selected one are always ignored.
- R6: A control write leaves the length field unchanged if the stored enable bit is 1 at the time of the write, even when the same write clears the enable bit. The other fields are always written.
- R7: A trigger during a burst while fewer than L requests have been acknowledged sets ovrFlag (status address 1, bit 0). The trigger is discarded and the burst still delivers exactly L+1 requests.
- R8: A trigger that arrives while the last request of a burst is outstanding is not an overrun. A new burst of L+1 requests follows directly after that final acknowledge, with dmaReq staying high.
- R9: Writing a word with bit 0 set to address 2 clears ovrFlag. Writing 0 there has no effect. An overrun in the same cycle as a clear leaves the flag set.
- R10: irqOut is high exactly when ovrFlag and the interrupt enable bit are both 1.
- R11: Clearing the enable bit aborts a burst. dmaReq is low one cycle after the write, and the next burst starts again from a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigIn | input | 32 | Trigger lines |
| dmaAck | input | 1 | Acknowledge for the current request |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr |
| dmaReq | output | 1 | Generated DMA request |
| irqOut | output | 1 | Overrun interrupt |
| ovrFlag | output | 1 | Sticky overrun flag |

## Verification
A wrong request counter shows up as a burst with the wrong number of acknowledged requests. It becomes visible on dmaReq one cycle after the acknowledge where the burst should have ended. A wrong burst state or a lost pending trigger changes dmaReq within a cycle of the edge or the final acknowledge. A wrong overrun decision shows on ovrFlag and irqOut in the cycle after the offending edge is detected. The bench sweeps every edge mode against both edge directions, several lengths and several line selects. It also checks the overrun, pending-restart, abort and locking cases at the cycle where each one decides.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int TRIG_N  = 32;
  localparam int CNT_W   = 5;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;

  // control word field positions (software-visible layout)
  localparam int SEL_LSB  = 0;
  localparam int IE_BIT   = 8;
  localparam int GE_BIT   = 16;
  localparam int EDGE_LSB = 17;
  localparam int LEN_LSB  = 19;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 2'd2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeMode_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } genState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic setOvr;
  } genStrobe_t;
endpackage

// File: rtl/brg_dpath.sv
module brg_dpath
  import brg_pkg::*;
#(
  parameter int NTRIG = TRIG_N,
  parameter int CW    = CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NTRIG-1:0]    trigIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  genStrobe_t          strobe,
  output logic                trigEvent,
  output logic                geBit,
  output logic                ieBit,
  output logic [CW-1:0]       lenCode,
  output logic [CW-1:0]       cnt,
  output logic                atLast,
  output logic                ovrFlag
);
  localparam int SEL_W = $clog2(NTRIG);

  logic [SEL_W-1:0] selReg;
  edgeMode_t        edgeReg;
  logic [NTRIG-1:0] prevVec;
  logic [NTRIG-1:0] riseVec;
  logic [NTRIG-1:0] fallVec;
  logic             ctrlWr;
  logic             clrHit;
  logic             unusedWr;

  assign ctrlWr   = regWrEn && (regAddr == ADR_CTRL);
  assign clrHit   = regWrEn && (regAddr == ADR_CLR) && regWrData[0];
  assign unusedWr = ^regWrData;

  // per-line edge detection, so a change of select never fakes an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= '0;
    else       prevVec <= trigIn;
  end

  for (genvar i = 0; i < NTRIG; i++) begin : g_edge
    assign riseVec[i] = trigIn[i] & ~prevVec[i];
    assign fallVec[i] = ~trigIn[i] & prevVec[i];
  end

  always_comb begin
    trigEvent = 1'b0;
    if (geBit) begin
      case (edgeReg)
        EDGE_RISE: trigEvent = riseVec[selReg];
        EDGE_FALL: trigEvent = fallVec[selReg];
        EDGE_BOTH: trigEvent = riseVec[selReg] | fallVec[selReg];
        default:   trigEvent = 1'b0;
      endcase
    end
  end

  // control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      ieBit   <= 1'b0;
      geBit   <= 1'b0;
      edgeReg <= EDGE_NONE;
      lenCode <= '0;
    end else if (ctrlWr) begin
      selReg  <= regWrData[SEL_LSB +: SEL_W];
      ieBit   <= regWrData[IE_BIT];
      geBit   <= regWrData[GE_BIT];
      edgeReg <= edgeMode_t'(regWrData[EDGE_LSB +: 2]);
      if (!geBit) lenCode <= regWrData[LEN_LSB +: CW];
    end
  end

  // request counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  assign atLast = (cnt == lenCode);

  // sticky overrun flag, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ovrFlag <= 1'b0;
    else if (strobe.setOvr) ovrFlag <= 1'b1;
    else if (clrHit)        ovrFlag <= 1'b0;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_CTRL: begin
        regRdData[SEL_LSB +: SEL_W] = selReg;
        regRdData[IE_BIT]           = ieBit;
        regRdData[GE_BIT]           = geBit;
        regRdData[EDGE_LSB +: 2]    = edgeReg;
        regRdData[LEN_LSB +: CW]    = lenCode;
      end
      ADR_STAT: regRdData[0] = ovrFlag;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       geBit,
  input  logic       trigEvent,
  input  logic       dmaAck,
  input  logic       atLast,
  output genStrobe_t strobe,
  output logic       dmaReq
);
  genState_t state, nxtState;
  logic      pend, nxtPend;

  always_comb begin
    strobe   = '0;
    nxtState = state;
    nxtPend  = pend;
    if (!geBit) begin
      nxtState        = ST_IDLE;
      nxtPend         = 1'b0;
      strobe.cntClear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigEvent) begin
            nxtState        = ST_BURST;
            strobe.cntClear = 1'b1;
          end
        end
        ST_BURST: begin
          if (trigEvent && !atLast) strobe.setOvr = 1'b1;
          if (dmaAck) begin
            if (atLast) begin
              strobe.cntClear = 1'b1;
              nxtPend         = 1'b0;
              if (!(pend || trigEvent)) nxtState = ST_IDLE;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end else if (trigEvent && atLast) begin
            nxtPend = 1'b1;
          end
        end
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= nxtState;
      pend  <= nxtPend;
    end
  end

  assign dmaReq = (state == ST_BURST);
endmodule

// File: rtl/burst_req_gen.sv
module burst_req_gen
  import brg_pkg::*;
#(
  parameter int NTRIG = TRIG_N,
  parameter int CW    = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NTRIG-1:0]  trigIn,
  input  logic              dmaAck,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              dmaReq,
  output logic              irqOut,
  output logic              ovrFlag
);
  genStrobe_t    strobe;
  logic          trigEvent;
  logic          geBit;
  logic          ieBit;
  logic [CW-1:0] lenCode;
  logic [CW-1:0] cnt;
  logic          atLast;

  brg_dpath #(.NTRIG(NTRIG), .CW(CW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .trigEvent (trigEvent),
    .geBit     (geBit),
    .ieBit     (ieBit),
    .lenCode   (lenCode),
    .cnt       (cnt),
    .atLast    (atLast),
    .ovrFlag   (ovrFlag)
  );

  brg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .geBit     (geBit),
    .trigEvent (trigEvent),
    .dmaAck    (dmaAck),
    .atLast    (atLast),
    .strobe    (strobe),
    .dmaReq    (dmaReq)
  );

  assign irqOut = ovrFlag & ieBit;
endmodule

// File: rtl/brg_checker.sv
module brg_checker
  import brg_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaReq,
  input logic              dmaAck,
  input logic              ovrFlag,
  input logic              geBit,
  input logic [CW-1:0]     lenCode,
  input logic [CW-1:0]     cnt,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWrData
);
  logic clrWrite;
  assign clrWrite = regWrEn && (regAddr == ADR_CLR) && regWrData[0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (cnt <= lenCode)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck && geBit) |=> dmaReq); // R4

  AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(geBit) |-> $stable(lenCode)); // R6

  AST_OVR_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(dmaReq)); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovrFlag) |-> $past(clrWrite)); // R9

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !geBit |=> !dmaReq); // R11
endmodule

bind burst_req_gen brg_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dmaReq    (dmaReq),
  .dmaAck    (dmaAck),
  .ovrFlag   (ovrFlag),
  .geBit     (geBit),
  .lenCode   (lenCode),
  .cnt       (cnt),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData)
);

// File: tb/burst_req_gen_tb.sv
`timescale 1ns/1ps
module burst_req_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] trigIn = '0;
  logic        dmaAck = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        dmaReq, irqOut, ovrFlag;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  burst_req_gen u_dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .dmaAck(dmaAck),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .dmaReq(dmaReq), .irqOut(irqOut), .ovrFlag(ovrFlag)
  );

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(int sel, int ie, int ge, int mode, int len);
    return (32'(len) << 19) | (32'(mode) << 17) | (32'(ge) << 16) | (32'(ie) << 8) | 32'(sel);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cyc();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (dmaReq && n < 100) begin
      dmaAck = 1'b1; cyc(); n++;
    end
    dmaAck = 1'b0;
  endtask

  // one sweep point: line sel, edge mode, length code, edge direction (1 = rising)
  task automatic runCase(int sel, int mode, int len, int rising);
    int n;
    int fire;
    fire = (rising != 0) ? (mode & 1) : ((mode >> 1) & 1);
    trigIn[sel] = (rising != 0) ? 1'b0 : 1'b1;
    wr(2'd0, ctrlWord(sel, 0, 0, mode, len));
    wr(2'd0, ctrlWord(sel, 0, 1, mode, len));
    trigIn[sel] = (rising != 0) ? 1'b1 : 1'b0;
    cyc();
    chk($sformatf("R3 start sel=%0d mode=%0d dir=%0d", sel, mode, rising), int'(dmaReq), fire);
    drain(n);
    chk($sformatf("R4 count len=%0d mode=%0d dir=%0d", len, mode, rising), n, fire * (len + 1));
    wr(2'd0, ctrlWord(sel, 0, 0, mode, len));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    int lens[6] = '{0, 1, 2, 3, 7, 31};
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 dmaReq", int'(dmaReq), 0);
    chk("R1 irqOut", int'(irqOut), 0);
    chk("R1 ovrFlag", int'(ovrFlag), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk($sformatf("R1 read addr %0d", a), int'(d), 0);
    end

    // R2 field layout and readback, R6 lock through the same write
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 readback all ones", int'(d), int'(32'h00FF_011F));
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R6 length kept when clearing enable", int'(d), int'(32'h00F8_0000));
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R6 length written while disabled", int'(d), 0);

    // R3/R4 sweep: lengths x modes x directions
    for (int li = 0; li < 6; li++)
      for (int m = 0; m < 4; m++)
        for (int dir = 0; dir < 2; dir++)
          runCase((li * 5 + m * 3 + dir * 11) % 32, m, lens[li], dir);

    // R5 disabled and unselected lines
    trigIn = '0;
    wr(2'd0, ctrlWord(5, 0, 0, 3, 2));
    trigIn[5] = 1'b1; cyc(); cyc();
    chk("R5 disabled rise ignored", int'(dmaReq), 0);
    trigIn[5] = 1'b0; cyc(); cyc();
    chk("R5 disabled fall ignored", int'(dmaReq), 0);
    wr(2'd0, ctrlWord(5, 0, 1, 3, 2));
    trigIn[6] = 1'b1; cyc(); cyc();
    chk("R5 other line rise ignored", int'(dmaReq), 0);
    trigIn[6] = 1'b0; cyc(); cyc();
    chk("R5 other line fall ignored", int'(dmaReq), 0);
    wr(2'd0, ctrlWord(5, 0, 0, 3, 2));

    // R6 length locked while enabled
    wr(2'd0, ctrlWord(12, 0, 1, 1, 2));
    wr(2'd0, ctrlWord(12, 0, 1, 1, 7));
    rd(2'd0, d); chk("R6 length field locked", int'(d[23:19]), 2);
    trigIn[12] = 1'b1; cyc();
    drain(n); chk("R6 burst uses old length", n, 3);
    wr(2'd0, ctrlWord(12, 0, 0, 1, 0));
    trigIn[12] = 1'b0;

    // R7/R9/R10 overrun, clear, interrupt
    wr(2'd0, ctrlWord(9, 0, 0, 1, 3));
    wr(2'd0, ctrlWord(9, 1, 1, 1, 3));
    trigIn[9] = 1'b1; cyc();
    dmaAck = 1'b1; cyc(); dmaAck = 1'b0;
    trigIn[9] = 1'b0; cyc();
    trigIn[9] = 1'b1; cyc();
    chk("R7 overrun flag set", int'(ovrFlag), 1);
    chk("R10 irq with enable", int'(irqOut), 1);
    rd(2'd1, d); chk("R7 status bit0", int'(d), 1);
    wr(2'd2, 32'h0);
    chk("R9 clear with zero ignored", int'(ovrFlag), 1);
    wr(2'd0, ctrlWord(9, 0, 1, 1, 3));
    chk("R10 irq masked", int'(irqOut), 0);
    chk("R10 flag kept when masked", int'(ovrFlag), 1);
    wr(2'd0, ctrlWord(9, 1, 1, 1, 3));
    wr(2'd2, 32'h1);
    chk("R9 clear by one", int'(ovrFlag), 0);
    chk("R10 irq low after clear", int'(irqOut), 0);
    trigIn[9] = 1'b0; cyc();
    trigIn[9] = 1'b1; regWrEn = 1'b1; regAddr = 2'd2; regWrData = 32'h1;
    cyc();
    regWrEn = 1'b0; regWrData = '0;
    chk("R9 set wins over clear", int'(ovrFlag), 1);
    drain(n); chk("R7 burst unchanged after overruns", n, 3);
    cyc(); cyc();
    chk("R7 extra trigger discarded", int'(dmaReq), 0);
    wr(2'd2, 32'h1);
    wr(2'd0, ctrlWord(9, 0, 0, 1, 0));
    trigIn[9] = 1'b0;

    // R8 trigger while last request outstanding
    wr(2'd0, ctrlWord(20, 0, 0, 1, 1));
    wr(2'd0, ctrlWord(20, 0, 1, 1, 1));
    trigIn[20] = 1'b1; cyc();
    dmaAck = 1'b1; cyc(); dmaAck = 1'b0;
    trigIn[20] = 1'b0; cyc();
    trigIn[20] = 1'b1; cyc();
    chk("R8 no overrun at last", int'(ovrFlag), 0);
    drain(n); chk("R8 chained burst count", n, 3);
    wr(2'd0, ctrlWord(20, 0, 0, 1, 0));
    trigIn[20] = 1'b0;

    // R11 abort and restart from zero
    wr(2'd0, ctrlWord(3, 0, 0, 1, 5));
    wr(2'd0, ctrlWord(3, 0, 1, 1, 5));
    trigIn[3] = 1'b1; cyc();
    dmaAck = 1'b1; cyc(); cyc(); dmaAck = 1'b0;
    wr(2'd0, ctrlWord(3, 0, 0, 1, 5));
    cyc();
    chk("R11 request dropped on abort", int'(dmaReq), 0);
    trigIn[3] = 1'b0;
    wr(2'd0, ctrlWord(3, 0, 1, 1, 5));
    trigIn[3] = 1'b1; cyc();
    drain(n); chk("R11 full burst after abort", n, 6);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule